// File: doc/BRIEF.md
# Partial-Array Temperature-Compensated Refresh Scheduler

This block decides when a pseudo-static DRAM array refreshes itself while it sits in standby, and which row each refresh should target. A tick divider sets the refresh rate. Each expired tick raises a refresh request that carries a row number. A row pointer steps through the rows that are still kept alive and wraps back to zero at the top of that region.

An 8-bit configuration write port sets three independent controls:

- **Region size.** A 3-bit field keeps either the whole array or a low-addressed fraction of it alive. The kept fraction always starts at row 0.
- **Refresh rate.** A 2-bit field names the case-temperature range. Hotter ranges refresh more often.
- **Deep power-down.** A single bit stops all refresh activity.

The requester on the other side answers each request with a one-cycle acknowledge. Only one request is ever outstanding.

Top module: `pasr_refresh_sched`

## Requirements
- R1: After reset the configuration reads as 0, which means full array, hottest range and power-down off. `ref_req_o` is low. The first request rises after exactly `BASE_DIV` clock cycles.
- R2: Configuration bits 2:0 select the refreshed region. Code 000 is all `2^ROW_W` rows, 001 is the lower half, 010 is the lower quarter and 011 is the lower eighth. Successive requests carry rows 0, 1, 2, … and wrap to 0 after the last row of the region.
- R3: Region codes 100 through 111 mean that no row is kept. While such a code is held, no request is raised and any pending request is dropped.
- R4: Configuration bits 6:5 select the tick divisor, which is `BASE_DIV << code`. Code 00 (hottest, up to 85 °C) gives the shortest period. Codes 01, 10 and 11 (up to 70, 45 and 15 °C) give 2×, 4× and 8× that period.
- R5: The region code and the temperature code act together and do not affect each other.
- R6: Configuration bit 4 set stops refresh completely. No request is raised, a pending request is withdrawn and the tick count restarts from zero.
- R7: A raised request stays high, with its row held stable, until `ref_ack_i` is seen. The request falls on the following cycle.
- R8: A tick that expires while a request is pending is discarded. Nothing is queued and the row pointer does not move.
- R9: A write that changes the region code returns the row pointer to 0. A write that leaves the region code unchanged keeps the pointer where it is.
- R10: A configuration write takes effect from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_data_i | input | 8 | Configuration value: bits 2:0 region, bit 4 power-down, bits 6:5 temperature |
| ref_req_o | output | 1 | Refresh request, held until acknowledged |
| ref_row_o | output | ROW_W | Row to refresh, valid while `ref_req_o` is high |
| ref_ack_i | input | 1 | Acknowledge of the pending request |

## Verification
The assertions check several properties on every cycle:

- A pending request keeps its row until it is acknowledged.
- Power-down or an empty region clears the request on the next cycle.
- A request rises only on an expiring tick.
- The row pointer stays inside the current region and wraps to zero at its top.
- The tick never fires on two cycles in a row.

Other behaviour can only be shown by the bench's scenarios, where the reference model is compared with the outputs on every cycle:

- The exact tick spacing for each temperature code.
- The region sizes and the wrap point of each region code.
- Discarding of ticks while acknowledge is withheld.
- Pointer reset when the region code changes and pointer retention when it does not.

// File: rtl/pasr_refresh_pkg.sv
package pasr_refresh_pkg;

    typedef enum logic [1:0] {
        TEMP_HOT  = 2'b00,
        TEMP_WARM = 2'b01,
        TEMP_MILD = 2'b10,
        TEMP_COLD = 2'b11
    } temp_range_e;

    typedef struct packed {
        temp_range_e temp;
        logic        pdown;
        logic [2:0]  region;
    } sched_cfg_t;

    localparam sched_cfg_t CFG_RESET = '{temp: TEMP_HOT, pdown: 1'b0, region: 3'b000};

    function automatic sched_cfg_t unpack_cfg(input logic [7:0] raw);
        sched_cfg_t c;
        c.region = raw[2:0];
        c.pdown  = raw[4];
        c.temp   = temp_range_e'(raw[6:5]);
        return c;
    endfunction

    function automatic logic region_kept(input logic [2:0] region);
        return ~region[2];
    endfunction

endpackage

// File: rtl/pasr_tick_div.sv
module pasr_tick_div
    import pasr_refresh_pkg::*;
#(
    parameter int BASE_DIV = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run_i,
    input  temp_range_e temp_i,
    output logic        tick_o
);
    localparam int CNT_W = $clog2(BASE_DIV * 8) + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_state_t;

    div_state_t       st_d, st_q;
    logic [CNT_W-1:0] limit_w;

    always_comb begin
        limit_w = CNT_W'((BASE_DIV << temp_i) - 1);
        tick_o  = run_i && (st_q.cnt >= limit_w);
        st_d    = st_q;
        if (!run_i || tick_o) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4: the counter restarts after every tick, so ticks are never back to back
    p_tick_spaced_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

    // R6: a stopped divider holds no count
    p_idle_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (st_q.cnt == '0));
endmodule

// File: rtl/pasr_row_ptr.sv
module pasr_row_ptr #(
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       region_i,
    input  logic             clear_i,
    input  logic             adv_i,
    output logic [ROW_W-1:0] ptr_o
);
    localparam int ROWS = 1 << ROW_W;

    typedef struct packed {
        logic [ROW_W-1:0] ptr;
    } ptr_state_t;

    ptr_state_t       st_d, st_q;
    logic [ROW_W:0]   span_w;
    logic [ROW_W-1:0] top_w;

    always_comb begin
        span_w = (ROW_W+1)'(ROWS) >> region_i[1:0];
        top_w  = ROW_W'(span_w - 1'b1);
        st_d   = st_q;
        if (clear_i) begin
            st_d.ptr = '0;
        end else if (adv_i) begin
            st_d.ptr = (st_q.ptr >= top_w) ? '0 : st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_o = st_q.ptr;

    // R2: the pointer never leaves the kept region
    p_ptr_in_region_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !region_i[2] |-> (st_q.ptr <= top_w));

    // R2: the last kept row wraps back to row zero
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !clear_i && st_q.ptr == top_w) |=> (st_q.ptr == '0));

    // R9: a clear always lands on row zero
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (st_q.ptr == '0));

    // R8: the pointer is frozen when neither advanced nor cleared
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !clear_i) |=> $stable(st_q.ptr));
endmodule

// File: rtl/pasr_refresh_sched.sv
module pasr_refresh_sched
    import pasr_refresh_pkg::*;
#(
    parameter int ROW_W    = 12,
    parameter int BASE_DIV = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_i,
    input  logic [7:0]       cfg_data_i,
    output logic             ref_req_o,
    output logic [ROW_W-1:0] ref_row_o,
    input  logic             ref_ack_i
);
    typedef struct packed {
        sched_cfg_t       cfg;
        logic             req;
        logic [ROW_W-1:0] row;
    } top_state_t;

    top_state_t       st_d, st_q;
    sched_cfg_t       wr_cfg_w;
    logic             active_w;
    logic             tick_w;
    logic             issue_w;
    logic             ptr_clear_w;
    logic [ROW_W-1:0] ptr_w;

    pasr_tick_div #(.BASE_DIV(BASE_DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (active_w),
        .temp_i (st_q.cfg.temp),
        .tick_o (tick_w)
    );

    pasr_row_ptr #(.ROW_W(ROW_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .region_i (st_q.cfg.region),
        .clear_i  (ptr_clear_w),
        .adv_i    (issue_w),
        .ptr_o    (ptr_w)
    );

    always_comb begin
        wr_cfg_w    = unpack_cfg(cfg_data_i);
        active_w    = !st_q.cfg.pdown && region_kept(st_q.cfg.region);
        issue_w     = tick_w && !st_q.req;
        ptr_clear_w = cfg_wr_i && (wr_cfg_w.region != st_q.cfg.region);
        st_d        = st_q;
        if (!active_w) begin
            st_d.req = 1'b0;
        end else if (issue_w) begin
            st_d.req = 1'b1;
            st_d.row = ptr_w;
        end else if (st_q.req && ref_ack_i) begin
            st_d.req = 1'b0;
        end
        if (cfg_wr_i) begin
            st_d.cfg = wr_cfg_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cfg: CFG_RESET, req: 1'b0, row: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ref_req_o = st_q.req;
    assign ref_row_o = st_q.row;

    // R7: an unanswered request persists with a fixed row
    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req_o && !ref_ack_i && active_w) |=> (ref_req_o && $stable(ref_row_o)));

    // R6 and R3: power-down or an empty region withdraws the request
    p_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !active_w |=> !ref_req_o);

    // R8: a request rises only on an expiring tick
    p_rise_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_req_o && !tick_w) |=> !ref_req_o);

    // R7: an acknowledged request is gone the next cycle
    p_ack_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req_o && ref_ack_i) |=> !ref_req_o);
endmodule

// File: tb/sim_pasr_refresh_sched.sv
module sim_pasr_refresh_sched;
    localparam int CLK_PERIOD = 10;
    localparam int ROW_W      = 5;
    localparam int BASE_DIV   = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_wr = 1'b0;
    logic [7:0]       cfg_data = '0;
    logic             req;
    logic [ROW_W-1:0] row;
    logic             ack = 1'b0;

    int    n_checks = 0;
    int    n_fail = 0;
    string tag = "R1";
    bit    hold_ack = 1'b0;
    int    req_seen = 0;

    // behavioural reference state
    int       m_cnt = 0;
    int       m_ptr = 0;
    bit       m_req = 1'b0;
    int       m_row = 0;
    bit [7:0] m_cfg = '0;

    pasr_refresh_sched #(.ROW_W(ROW_W), .BASE_DIV(BASE_DIV)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr_i   (cfg_wr),
        .cfg_data_i (cfg_data),
        .ref_req_o  (req),
        .ref_row_o  (row),
        .ref_ack_i  (ack)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (rst_n) begin
            bit active, tick;
            int div, rows;
            active = !m_cfg[4] && (m_cfg[2:0] < 3'd4);
            div    = BASE_DIV << m_cfg[6:5];
            rows   = (1 << ROW_W) >> m_cfg[1:0];
            tick   = active && (m_cnt >= div - 1);
            if (!active) begin
                m_cnt = 0;
                m_req = 1'b0;
            end else begin
                m_cnt = tick ? 0 : m_cnt + 1;
                if (tick && !m_req) begin
                    m_req = 1'b1;
                    m_row = m_ptr;
                    m_ptr = (m_ptr + 1 >= rows) ? 0 : m_ptr + 1;
                end else if (m_req && ack) begin
                    m_req = 1'b0;
                end
            end
            if (cfg_wr) begin
                if (cfg_data[2:0] != m_cfg[2:0]) m_ptr = 0;
                m_cfg = cfg_data;
            end
        end
    end

    task automatic check(input string rq, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", rq, act, exp, $time);
        end
    endtask

    // compare on every cycle, away from the clock edge, then drive the acknowledge
    always @(negedge clk) begin
        if (rst_n) begin
            check(tag, int'(req), int'(m_req));
            if (m_req) check(tag, int'(row), m_row);
            if (req) req_seen++;
            ack <= req && !hold_ack;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk);
        cfg_wr   <= 1'b1;
        cfg_data <= v;
        @(negedge clk);
        cfg_wr   <= 1'b0;
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
                $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;

        // R1: reset state, and the first request after BASE_DIV cycles
        @(negedge clk);
        check("R1", int'(req), 0);
        wait_cyc(BASE_DIV - 2);
        check("R1", int'(req), 0);
        @(negedge clk);
        check("R1", int'(req), 1);
        check("R1", int'(row), 0);
        wait_cyc(300);                              // full region wraps

        // R2: each kept region and its wrap point
        tag = "R2";
        write_cfg(8'h01); wait_cyc(200);
        write_cfg(8'h02); wait_cyc(120);
        write_cfg(8'h03); wait_cyc(80);

        // R4: each temperature divisor, on the eighth region
        tag = "R4";
        write_cfg(8'h23); wait_cyc(120);
        write_cfg(8'h43); wait_cyc(200);
        write_cfg(8'h63); wait_cyc(300);

        // R5: quarter region together with the 45 C range
        tag = "R5";
        write_cfg(8'h42); wait_cyc(400);

        // R3: empty-region codes raise nothing
        tag = "R3";
        write_cfg(8'h04);
        req_seen = 0;
        wait_cyc(100);
        write_cfg(8'h07);
        wait_cyc(100);
        check("R3", req_seen, 0);

        // R9: a region change restarts at row 0; same-region write keeps the pointer
        tag = "R9";
        write_cfg(8'h01); wait_cyc(30);
        write_cfg(8'h01); wait_cyc(40);

        // R8: withheld acknowledge discards ticks
        tag = "R8";
        hold_ack = 1'b1; wait_cyc(50);
        hold_ack = 1'b0; wait_cyc(20);

        // R6: power-down withdraws a held request and stops refresh
        tag = "R6";
        hold_ack = 1'b1; wait_cyc(10);
        write_cfg(8'h11);
        @(negedge clk);
        check("R6", int'(req), 0);
        req_seen = 0;
        wait_cyc(80);
        check("R6", req_seen, 0);
        hold_ack = 1'b0;

        // R10: writes take effect next cycle, covered by per-cycle compare
        tag = "R10";
        write_cfg(8'h00); wait_cyc(60);
        write_cfg(8'h62); wait_cyc(100);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule